// File: doc/BRIEF.md
# Exception Priority Mask Filter

This block decides whether one pending exception may be accepted by the core. It gets the exception's number, its priority value and two flags that mark it as the non-maskable interrupt or the hard fault. It applies three mask registers to them: a one-bit interrupt disable, a one-bit fault disable and a numeric priority threshold. The result is a registered take/hold decision.

The mask registers are written through simple enable/data ports. A write only takes effect when the requester is privileged. The block also keeps a 9-bit active-exception number, which loads the number of each exception it accepts. All three masks and the active number can be read back at any time. Choosing among several pending sources and fetching vectors are left to neighbouring logic.

Top module: `exc_mask_filter`

## Requirements
- R1: After reset, all three mask registers, the active-exception number and take_o read 0. An ordinary interrupt of any priority is then taken.
- R2: While the interrupt disable bit is 1, only a source flagged NMI or hard fault can be taken. Every other source is held.
- R3: While the fault disable bit is 1, only a source flagged NMI can be taken. Hard fault and ordinary sources are held.
- R4: While the threshold register is nonzero, a non-NMI source whose priority value is greater than or equal to the threshold is held. Hard fault is included. A source with a strictly lower value passes this check.
- R5: A threshold value of 0 masks no priority at all.
- R6: A valid source flagged NMI is taken under every combination of mask values.
- R7: Mask writes made while priv_i is 0 are ignored. The register keeps its value and so does the decision it drives.
- R8: take_o reflects the pending inputs and the mask values of the previous cycle. take_o is 0 whenever pend_valid_i was 0. hold_o is 1 exactly when a valid source was not taken.
- R9: When take_o rises, cur_exc_o holds the 9-bit number of the source taken. On a hold it keeps its old value.
- R10: A source is taken only if the interrupt disable check, the fault disable check and the threshold check all pass together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pend_valid_i | input | 1 | A source is pending this cycle |
| pend_num_i | input | 9 | Exception number of the pending source |
| pend_prio_i | input | PRIO_W | Priority value of the pending source (lower is more urgent) |
| pend_is_nmi_i | input | 1 | Pending source is the NMI |
| pend_is_hf_i | input | 1 | Pending source is the hard fault |
| priv_i | input | 1 | 1 = privileged requester, 0 = user level |
| irq_dis_we_i | input | 1 | Write enable, interrupt disable bit |
| irq_dis_d_i | input | 1 | Write data, interrupt disable bit |
| flt_dis_we_i | input | 1 | Write enable, fault disable bit |
| flt_dis_d_i | input | 1 | Write data, fault disable bit |
| thresh_we_i | input | 1 | Write enable, priority threshold |
| thresh_d_i | input | PRIO_W | Write data, priority threshold |
| take_o | output | 1 | Registered decision: source accepted |
| hold_o | output | 1 | Registered decision: valid source held |
| irq_dis_o | output | 1 | Interrupt disable readback |
| flt_dis_o | output | 1 | Fault disable readback |
| thresh_o | output | PRIO_W | Threshold readback |
| cur_exc_o | output | 9 | Active-exception number |

## Verification
The bench steps through every setting of the two disable bits and of a zero or nonzero threshold. Under each setting it sends an ordinary interrupt, a hard fault and an NMI at priorities below, at and above the threshold. This exposes a filter that ORs the masks, lets the fault disable pass hard fault, or lets the threshold mask the NMI. The threshold edge is probed at exactly equal and one-below values, which catches a strict-versus-inclusive comparison error. It is also probed after the threshold returns to 0, which catches a design that treats 0 as the highest level. User-level writes are attempted on every register and then read back, so a design that drops the privilege gate shows up. The one-cycle latency and the loading of the active number are checked on every decision.

// File: rtl/exc_mask_pkg.sv
package exc_mask_pkg;
  localparam int unsigned EXC_NUM_W = 9;
  typedef logic [EXC_NUM_W-1:0] exc_num_t;
  typedef enum logic [1:0] {
    CHK_IRQ_DIS = 2'd0,
    CHK_FLT_DIS = 2'd1,
    CHK_THRESH  = 2'd2
  } chk_idx_e;
  localparam int unsigned NUM_CHK = 3;
endpackage

// File: rtl/exc_mask_regs.sv
module exc_mask_regs #(
  parameter int unsigned PRIO_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              priv_i,
  input  logic              irq_dis_we_i,
  input  logic              irq_dis_d_i,
  input  logic              flt_dis_we_i,
  input  logic              flt_dis_d_i,
  input  logic              thresh_we_i,
  input  logic [PRIO_W-1:0] thresh_d_i,
  output logic              irq_dis_o,
  output logic              flt_dis_o,
  output logic [PRIO_W-1:0] thresh_o
);
  logic              irq_dis_q, flt_dis_q;
  logic [PRIO_W-1:0] thresh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_dis_q <= 1'b0;
      flt_dis_q <= 1'b0;
      thresh_q  <= '0;
    end else if (priv_i) begin
      if (irq_dis_we_i) irq_dis_q <= irq_dis_d_i;
      if (flt_dis_we_i) flt_dis_q <= flt_dis_d_i;
      if (thresh_we_i)  thresh_q  <= thresh_d_i;
    end
  end

  assign irq_dis_o = irq_dis_q;
  assign flt_dis_o = flt_dis_q;
  assign thresh_o  = thresh_q;

  assert_user_irq_dis_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!priv_i && irq_dis_we_i) |=> $stable(irq_dis_q));
  assert_user_flt_dis_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!priv_i && flt_dis_we_i) |=> $stable(flt_dis_q));
  assert_user_thresh_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!priv_i && thresh_we_i) |=> $stable(thresh_q));
endmodule

// File: rtl/exc_mask_eval.sv
module exc_mask_eval
  import exc_mask_pkg::*;
#(
  parameter int unsigned PRIO_W = 8
) (
  input  logic               valid_i,
  input  logic [PRIO_W-1:0]  prio_i,
  input  logic               is_nmi_i,
  input  logic               is_hf_i,
  input  logic               irq_dis_i,
  input  logic               flt_dis_i,
  input  logic [PRIO_W-1:0]  thresh_i,
  output logic [NUM_CHK-1:0] pass_o,
  output logic               take_o
);
  logic thresh_active;
  assign thresh_active = (thresh_i != '0);

  always_comb begin
    pass_o              = '0;
    pass_o[CHK_IRQ_DIS] = !irq_dis_i || is_nmi_i || is_hf_i;
    pass_o[CHK_FLT_DIS] = !flt_dis_i || is_nmi_i;
    pass_o[CHK_THRESH]  = !thresh_active || is_nmi_i || (prio_i < thresh_i);
  end

  // all checks must pass; NMI passes each of them by itself
  assign take_o = valid_i && (&pass_o);
endmodule

// File: rtl/exc_mask_filter.sv
module exc_mask_filter
  import exc_mask_pkg::*;
#(
  parameter int unsigned PRIO_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pend_valid_i,
  input  logic [EXC_NUM_W-1:0] pend_num_i,
  input  logic [PRIO_W-1:0]    pend_prio_i,
  input  logic                 pend_is_nmi_i,
  input  logic                 pend_is_hf_i,
  input  logic                 priv_i,
  input  logic                 irq_dis_we_i,
  input  logic                 irq_dis_d_i,
  input  logic                 flt_dis_we_i,
  input  logic                 flt_dis_d_i,
  input  logic                 thresh_we_i,
  input  logic [PRIO_W-1:0]    thresh_d_i,
  output logic                 take_o,
  output logic                 hold_o,
  output logic                 irq_dis_o,
  output logic                 flt_dis_o,
  output logic [PRIO_W-1:0]    thresh_o,
  output logic [EXC_NUM_W-1:0] cur_exc_o
);
  logic              irq_dis, flt_dis;
  logic [PRIO_W-1:0] thresh;
  logic [NUM_CHK-1:0] pass;
  logic              take_d;
  logic              take_q, hold_q;
  exc_num_t          cur_q;

  exc_mask_regs #(.PRIO_W(PRIO_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .priv_i      (priv_i),
    .irq_dis_we_i(irq_dis_we_i),
    .irq_dis_d_i (irq_dis_d_i),
    .flt_dis_we_i(flt_dis_we_i),
    .flt_dis_d_i (flt_dis_d_i),
    .thresh_we_i (thresh_we_i),
    .thresh_d_i  (thresh_d_i),
    .irq_dis_o   (irq_dis),
    .flt_dis_o   (flt_dis),
    .thresh_o    (thresh)
  );

  exc_mask_eval #(.PRIO_W(PRIO_W)) u_eval (
    .valid_i  (pend_valid_i),
    .prio_i   (pend_prio_i),
    .is_nmi_i (pend_is_nmi_i),
    .is_hf_i  (pend_is_hf_i),
    .irq_dis_i(irq_dis),
    .flt_dis_i(flt_dis),
    .thresh_i (thresh),
    .pass_o   (pass),
    .take_o   (take_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_q <= 1'b0;
      hold_q <= 1'b0;
      cur_q  <= '0;
    end else begin
      take_q <= take_d;
      hold_q <= pend_valid_i && !take_d;
      if (take_d) cur_q <= pend_num_i;
    end
  end

  assign take_o    = take_q;
  assign hold_o    = hold_q;
  assign irq_dis_o = irq_dis;
  assign flt_dis_o = flt_dis;
  assign thresh_o  = thresh;
  assign cur_exc_o = cur_q;

  assert_take_needs_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_valid_i |=> !take_o);
  assert_take_hold_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(take_o && hold_o));
  assert_nmi_taken_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_valid_i && pend_is_nmi_i) |=> take_o);
  assert_irq_dis_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_valid_i && irq_dis && !pend_is_nmi_i && !pend_is_hf_i) |=> hold_o);
  assert_flt_dis_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_valid_i && flt_dis && !pend_is_nmi_i) |=> hold_o);
  assert_thresh_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_valid_i && thresh != '0 && !pend_is_nmi_i && pend_prio_i >= thresh) |=> hold_o);
  assert_all_pass_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_valid_i && !irq_dis && !flt_dis && thresh == '0) |=> take_o);
  assert_cur_exc_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_d |=> (cur_exc_o == $past(pend_num_i)));
  assert_cur_exc_keep_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_d |=> $stable(cur_exc_o));
endmodule

// File: tb/tb_exc_mask_filter.sv
module tb_exc_mask_filter;
  localparam int PW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pend_valid = 1'b0;
  logic [8:0]    pend_num = '0;
  logic [PW-1:0] pend_prio = '0;
  logic          is_nmi = 1'b0, is_hf = 1'b0, priv = 1'b0;
  logic          pm_we = 1'b0, pm_d = 1'b0, fm_we = 1'b0, fm_d = 1'b0, bp_we = 1'b0;
  logic [PW-1:0] bp_d = '0;
  logic          take, hold, pm_o, fm_o;
  logic [PW-1:0] bp_o;
  logic [8:0]    cur;

  int checks = 0, errors = 0, cyc = 0;
  logic          m_pm = 0, m_fm = 0;
  logic [PW-1:0] m_bp = '0;
  logic [8:0]    m_cur = '0;

  typedef struct {int due; logic exp_take; logic [8:0] exp_cur; string tag;} item_t;
  item_t sb[$];

  exc_mask_filter #(.PRIO_W(PW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pend_valid_i(pend_valid), .pend_num_i(pend_num),
    .pend_prio_i(pend_prio), .pend_is_nmi_i(is_nmi), .pend_is_hf_i(is_hf), .priv_i(priv),
    .irq_dis_we_i(pm_we), .irq_dis_d_i(pm_d), .flt_dis_we_i(fm_we), .flt_dis_d_i(fm_d),
    .thresh_we_i(bp_we), .thresh_d_i(bp_d), .take_o(take), .hold_o(hold),
    .irq_dis_o(pm_o), .flt_dis_o(fm_o), .thresh_o(bp_o), .cur_exc_o(cur));

  always #10ns clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: compare scoreboard items when their result is due
  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].due == cyc) begin
      item_t it;
      it = sb.pop_front();
      chk({it.tag, " take"}, int'(take), int'(it.exp_take));
      chk({it.tag, " hold"}, int'(hold), int'(!it.exp_take && it.tag != "R8_idle"));
      chk({it.tag, " cur_exc R9"}, int'(cur), int'(it.exp_cur));
    end
  end

  // driver: one pending source for one cycle, called at a negedge
  task automatic req(input logic v, input logic [8:0] num, input logic [PW-1:0] pr,
                     input logic nmi, input logic hf);
    item_t it;
    string tag;
    logic t;
    pend_valid = v; pend_num = num; pend_prio = pr; is_nmi = nmi; is_hf = hf;
    t = 1'b1; tag = "R10_pass";
    if (!v) begin t = 0; tag = "R8_idle"; end
    else if (nmi) tag = "R6_nmi";
    else begin
      if (m_pm && !hf) begin t = 0; tag = "R2_irq_dis"; end
      if (m_fm) begin t = 0; tag = "R3_flt_dis"; end
      if (m_bp != 0 && pr >= m_bp) begin t = 0; tag = "R4_thresh"; end
      if (t && m_bp == 0) tag = "R5_thresh_zero";
    end
    if (t) m_cur = num;
    it.due = cyc + 1; it.exp_take = t; it.exp_cur = m_cur; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    pend_valid = 1'b0; is_nmi = 1'b0; is_hf = 1'b0;
  endtask

  task automatic wr(input int which, input logic [PW-1:0] val, input logic p);
    priv = p;
    case (which)
      0: begin pm_we = 1; pm_d = val[0]; end
      1: begin fm_we = 1; fm_d = val[0]; end
      default: begin bp_we = 1; bp_d = val; end
    endcase
    @(negedge clk);
    pm_we = 0; fm_we = 0; bp_we = 0; priv = 0;
    if (p) begin
      if (which == 0) m_pm = val[0];
      else if (which == 1) m_fm = val[0];
      else m_bp = val;
    end
    chk(p ? "wr readback irq_dis" : "R7 user irq_dis", int'(pm_o), int'(m_pm));
    chk(p ? "wr readback flt_dis" : "R7 user flt_dis", int'(fm_o), int'(m_fm));
    chk(p ? "wr readback thresh" : "R7 user thresh", int'(bp_o), int'(m_bp));
  endtask

  initial begin
    #(20ns * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [PW-1:0] prios [3];
    prios[0] = 8'h10; prios[1] = 8'h40; prios[2] = 8'h80;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset irq_dis", int'(pm_o), 0);
    chk("R1 reset flt_dis", int'(fm_o), 0);
    chk("R1 reset thresh", int'(bp_o), 0);
    chk("R1 reset take", int'(take), 0);
    chk("R1 reset cur_exc", int'(cur), 0);
    req(1, 9'd20, 8'hFF, 0, 0);
    req(0, 9'd33, 8'h00, 1, 0);

    for (int pm = 0; pm < 2; pm++)
      for (int fm = 0; fm < 2; fm++)
        for (int b = 0; b < 2; b++) begin
          wr(0, PW'(pm), 1);
          wr(1, PW'(fm), 1);
          wr(2, b ? 8'h40 : 8'h00, 1);
          for (int k = 0; k < 3; k++)
            for (int p = 0; p < 3; p++)
              req(1, 9'(16 + pm*64 + fm*32 + b*16 + k*4 + p), prios[p], k == 2, k == 1);
        end

    wr(0, 0, 1); wr(1, 0, 1);
    wr(2, 8'h20, 1);
    req(1, 9'd100, 8'h20, 0, 0);
    req(1, 9'd101, 8'h1F, 0, 0);
    req(1, 9'd102, 8'hFF, 0, 0);
    req(1, 9'd103, 8'h20, 0, 1);
    wr(2, 8'h01, 1);
    req(1, 9'd104, 8'h00, 0, 0);
    req(1, 9'd105, 8'h01, 0, 0);
    wr(2, 8'h00, 1);
    req(1, 9'd106, 8'hFF, 0, 0);

    wr(0, 1, 0);
    wr(1, 1, 0);
    wr(2, 8'h05, 0);
    req(1, 9'd300, 8'hFF, 0, 0);
    wr(1, 1, 1);
    wr(1, 0, 0);
    req(1, 9'd301, 8'h00, 0, 0);
    req(1, 9'd511, 8'hFF, 1, 0);

    repeat (3) @(negedge clk);
    chk("R8 scoreboard drained", sb.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule